// File: doc/BRIEF.md
# Quadtree Above-Right Feature-Pair Detector

The block receives two binary feature maps, `a_map` and `b_map`, that cover the same square grid of side N = 2^K. It answers one question: is there a cell holding an `a` feature and another cell holding a `b` feature such that the `b` cell lies strictly further right and strictly higher than the `a` cell? When such a pair exists, it also reports one pair of coordinates that proves it.

The block does not compare every `a` cell against every `b` cell. Each square region is reduced to a short summary: whether it holds any `a` or any `b`, the leftmost and lowest `a` positions, the rightmost and highest `b` positions, a local detection flag and a witness. A tree of identical merge nodes combines four quadrant summaries into the summary of the enclosing square. There is one register stage per tree level, so a new map pair can enter on every clock and the result leaves K cycles later.

Top module: `quadtree_pair_detector`

## Requirements
- R1: Cell (x,y) is bit y*N+x of each map, with x counting rightward from 0 and y counting upward from 0 at the bottom row. `found` is 1 exactly when some a cell (xa,ya) and some b cell (xb,yb) satisfy xa<xb and ya<yb.
- R2: Both comparisons are strict. An a cell and a b cell on the same row or the same column never make `found` 1 by themselves.
- R3: If `a_map` is all zero or `b_map` is all zero, `found` is 0.
- R4: When `found` is 1, `a_map` is 1 at (`i_x`,`i_y`), `b_map` is 1 at (`j_x`,`j_y`), and `i_x`<`j_x` and `i_y`<`j_y`.
- R5: A merge node takes its witness from the first rule that applies, in this order: a flagged quadrant (lower-left, lower-right, upper-left, upper-right), then a side-by-side pair (bottom before top), then a stacked pair (left before right), then the diagonal lower-left/upper-right pair. For K=3, with an a at (0,0), b cells at (1,1) and (7,7), and nothing else, the witness is i=(0,0), j=(1,1).
- R6: A map pair sampled with `in_valid` high at a rising edge produces exactly one `out_valid` pulse. That pulse is high after the K-th rising edge, counting the sampling edge as the first.
- R7: Map pairs may be presented on consecutive cycles. Each one yields its own correct result, and results come out in input order.
- R8: While reset is held, and after reset until the first sampled map has worked through the pipeline, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Samples the two maps at this edge |
| a_map | input | N*N | First feature map, bit y*N+x |
| b_map | input | N*N | Second feature map, bit y*N+x |
| out_valid | output | 1 | Result for one sampled map pair |
| found | output | 1 | An above-right pair exists |
| i_x | output | K | Witness a cell, column |
| i_y | output | K | Witness a cell, row |
| j_x | output | K | Witness b cell, column |
| j_y | output | K | Witness b cell, row |

## Verification
Sampling a new map pair and delivering the result of an earlier pair happen in the same cycle whenever maps arrive back to back. The bench forces this with long gap-free bursts of random maps. Each input is stamped with its cycle and placed in a queue. The monitor pops one entry for each `out_valid` pulse and judges it by the elapsed cycle count, by comparing `found` against an exhaustive scan of all cell pairs, and by checking that the reported witness cells really carry the features and satisfy the relation.

// File: rtl/qd_pkg.sv
package qd_pkg;

  // which merge rule produced a node's flag, highest priority first
  typedef enum logic [2:0] {
    MC_NONE,
    MC_INNER,
    MC_SIDE,
    MC_STACK,
    MC_DIAG
  } mcase_e;

  // quadrant order inside a merge node; the witness priority depends on it
  localparam int unsigned Q_LL = 0;
  localparam int unsigned Q_LR = 1;
  localparam int unsigned Q_UL = 2;
  localparam int unsigned Q_UR = 3;

  // flags (has_a, has_b, found) plus six points of two coordinates each
  function automatic int unsigned sum_width(input int unsigned cw);
    return 3 + 12 * cw;
  endfunction

  // first node index of tree level lvl when all levels are packed together
  function automatic int unsigned level_base(input int unsigned k, input int unsigned lvl);
    int unsigned acc;
    acc = 0;
    for (int unsigned m = 0; m < lvl; m++) begin
      acc += 1 << (2 * (k - m));
    end
    return acc;
  endfunction

endpackage

// File: rtl/qd_leaf.sv
module qd_leaf
  import qd_pkg::*;
#(
  parameter int CW = 3,
  parameter int X  = 0,
  parameter int Y  = 0
) (
  input  logic                      a_i,
  input  logic                      b_i,
  output logic [sum_width(CW)-1:0]  sum_o
);

  typedef struct packed {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } pt_t;

  typedef struct packed {
    logic has_a;
    logic has_b;
    logic found;
    pt_t  a_left;
    pt_t  a_low;
    pt_t  b_right;
    pt_t  b_high;
    pt_t  wit_i;
    pt_t  wit_j;
  } sum_t;

  pt_t  here;
  sum_t s;

  assign here.x = CW'(X);
  assign here.y = CW'(Y);

  // a single cell can never hold a pair: both comparisons are strict
  always_comb begin
    s.has_a   = a_i;
    s.has_b   = b_i;
    s.found   = 1'b0;
    s.a_left  = here;
    s.a_low   = here;
    s.b_right = here;
    s.b_high  = here;
    s.wit_i   = here;
    s.wit_j   = here;
  end

  assign sum_o = s;

endmodule

// File: rtl/qd_merge.sv
module qd_merge
  import qd_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [4*sum_width(CW)-1:0] kids_i,
  output logic [sum_width(CW)-1:0]   sum_o
);

  localparam int SW = sum_width(CW);

  typedef struct packed {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } pt_t;

  typedef struct packed {
    logic has_a;
    logic has_b;
    logic found;
    pt_t  a_left;
    pt_t  a_low;
    pt_t  b_right;
    pt_t  b_high;
    pt_t  wit_i;
    pt_t  wit_j;
  } sum_t;

  sum_t   k [4];
  sum_t   s;
  mcase_e mcase;

  for (genvar q = 0; q < 4; q++) begin : g_unpack
    assign k[q] = kids_i[q*SW +: SW];
  end

  // cross-quadrant events, named so they can be probed
  logic side_bot, side_top, stack_left, stack_right, diag_hit, inner_hit;

  // side by side: columns already apart, so only the rows decide
  assign side_bot    = k[Q_LL].has_a && k[Q_LR].has_b &&
                       (k[Q_LL].a_low.y < k[Q_LR].b_high.y);
  assign side_top    = k[Q_UL].has_a && k[Q_UR].has_b &&
                       (k[Q_UL].a_low.y < k[Q_UR].b_high.y);
  // stacked: rows already apart, so only the columns decide
  assign stack_left  = k[Q_LL].has_a && k[Q_UL].has_b &&
                       (k[Q_LL].a_left.x < k[Q_UL].b_right.x);
  assign stack_right = k[Q_LR].has_a && k[Q_UR].has_b &&
                       (k[Q_LR].a_left.x < k[Q_UR].b_right.x);
  // diagonal: any a below-left with any b above-right
  assign diag_hit    = k[Q_LL].has_a && k[Q_UR].has_b;
  assign inner_hit   = k[Q_LL].found || k[Q_LR].found ||
                       k[Q_UL].found || k[Q_UR].found;

  always_comb begin
    logic seen_a;
    logic seen_b;
    pt_t  wi;
    pt_t  wj;

    s      = '0;
    seen_a = 1'b0;
    seen_b = 1'b0;

    // extremes: only quadrants that hold the feature may take part
    for (int q = 0; q < 4; q++) begin
      if (k[q].has_a) begin
        if (!seen_a || (k[q].a_left.x < s.a_left.x)) s.a_left = k[q].a_left;
        if (!seen_a || (k[q].a_low.y  < s.a_low.y))  s.a_low  = k[q].a_low;
        seen_a = 1'b1;
      end
      if (k[q].has_b) begin
        if (!seen_b || (k[q].b_right.x > s.b_right.x)) s.b_right = k[q].b_right;
        if (!seen_b || (k[q].b_high.y  > s.b_high.y))  s.b_high  = k[q].b_high;
        seen_b = 1'b1;
      end
    end
    s.has_a = seen_a;
    s.has_b = seen_b;

    // witness selection in fixed priority
    wi    = '0;
    wj    = '0;
    mcase = MC_NONE;
    if (inner_hit) begin
      mcase = MC_INNER;
      for (int q = 3; q >= 0; q--) begin
        if (k[q].found) begin
          wi = k[q].wit_i;
          wj = k[q].wit_j;
        end
      end
    end else if (side_bot) begin
      mcase = MC_SIDE;
      wi    = k[Q_LL].a_low;
      wj    = k[Q_LR].b_high;
    end else if (side_top) begin
      mcase = MC_SIDE;
      wi    = k[Q_UL].a_low;
      wj    = k[Q_UR].b_high;
    end else if (stack_left) begin
      mcase = MC_STACK;
      wi    = k[Q_LL].a_left;
      wj    = k[Q_UL].b_right;
    end else if (stack_right) begin
      mcase = MC_STACK;
      wi    = k[Q_LR].a_left;
      wj    = k[Q_UR].b_right;
    end else if (diag_hit) begin
      mcase = MC_DIAG;
      wi    = k[Q_LL].a_left;
      wj    = k[Q_UR].b_right;
    end
    s.found = (mcase != MC_NONE);
    s.wit_i = wi;
    s.wit_j = wj;
  end

  assign sum_o = s;

endmodule

// File: rtl/qd_level.sv
module qd_level
  import qd_pkg::*;
#(
  parameter int CW       = 3,
  parameter int SIDE_OUT = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          vld_i,
  input  logic [4*SIDE_OUT*SIDE_OUT*sum_width(CW)-1:0]  kids_i,
  output logic                                          vld_o,
  output logic [SIDE_OUT*SIDE_OUT*sum_width(CW)-1:0]    nodes_o
);

  localparam int SW      = sum_width(CW);
  localparam int SIDE_IN = 2 * SIDE_OUT;
  localparam int NODES   = SIDE_OUT * SIDE_OUT;

  typedef struct packed {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } pt_t;

  typedef struct packed {
    logic has_a;
    logic has_b;
    logic found;
    pt_t  a_left;
    pt_t  a_low;
    pt_t  b_right;
    pt_t  b_high;
    pt_t  wit_i;
    pt_t  wit_j;
  } sum_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int NX  = n % SIDE_OUT;
    localparam int NY  = n / SIDE_OUT;
    localparam int ILL = (2*NY) * SIDE_IN + 2*NX;
    localparam int ILR = ILL + 1;
    localparam int IUL = ILL + SIDE_IN;
    localparam int IUR = ILL + SIDE_IN + 1;

    logic [SW-1:0] merged;
    sum_t          node_q;

    qd_merge #(.CW(CW)) u_merge (
      .kids_i ({kids_i[IUR*SW +: SW], kids_i[IUL*SW +: SW],
                kids_i[ILR*SW +: SW], kids_i[ILL*SW +: SW]}),
      .sum_o  (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     node_q <= '0;
      else if (vld_i) node_q <= merged;
    end

    assign nodes_o[n*SW +: SW] = node_q;

    AST_FOUND_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      node_q.found |-> (node_q.has_a && node_q.has_b)); // R3
    AST_WITNESS_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      node_q.found |-> ((node_q.wit_i.x < node_q.wit_j.x) &&
                        (node_q.wit_i.y < node_q.wit_j.y))); // R2
    AST_A_EXTREMES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      node_q.has_a |-> ((node_q.a_left.x <= node_q.a_low.x) &&
                        (node_q.a_low.y <= node_q.a_left.y))); // R1
    AST_B_EXTREMES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      node_q.has_b |-> ((node_q.b_right.x >= node_q.b_high.x) &&
                        (node_q.b_high.y >= node_q.b_right.y))); // R1
  end

endmodule

// File: rtl/quadtree_pair_detector.sv
module quadtree_pair_detector
  import qd_pkg::*;
#(
  parameter int K = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [(1<<K)*(1<<K)-1:0] a_map,
  input  logic [(1<<K)*(1<<K)-1:0] b_map,
  output logic                     out_valid,
  output logic                     found,
  output logic [K-1:0]             i_x,
  output logic [K-1:0]             i_y,
  output logic [K-1:0]             j_x,
  output logic [K-1:0]             j_y
);

  localparam int N     = 1 << K;
  localparam int CW    = K;
  localparam int SW    = sum_width(CW);
  localparam int TOTAL = level_base(K, K + 1);
  localparam int ROOT  = level_base(K, K);

  typedef struct packed {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } pt_t;

  typedef struct packed {
    logic has_a;
    logic has_b;
    logic found;
    pt_t  a_left;
    pt_t  a_low;
    pt_t  b_right;
    pt_t  b_high;
    pt_t  wit_i;
    pt_t  wit_j;
  } sum_t;

  // every level's node summaries packed back to back, leaves first
  logic [TOTAL*SW-1:0] all_sum;
  logic [K:0]          all_vld;

  assign all_vld[0] = in_valid;

  for (genvar c = 0; c < N*N; c++) begin : g_cell
    qd_leaf #(.CW(CW), .X(c % N), .Y(c / N)) u_leaf (
      .a_i   (a_map[c]),
      .b_i   (b_map[c]),
      .sum_o (all_sum[c*SW +: SW])
    );
  end

  for (genvar L = 1; L <= K; L++) begin : g_lvl
    localparam int SIDE = N >> L;
    localparam int BIN  = level_base(K, L - 1);
    localparam int BOUT = level_base(K, L);

    qd_level #(.CW(CW), .SIDE_OUT(SIDE)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (all_vld[L-1]),
      .kids_i  (all_sum[BIN*SW +: 4*SIDE*SIDE*SW]),
      .vld_o   (all_vld[L]),
      .nodes_o (all_sum[BOUT*SW +: SIDE*SIDE*SW])
    );
  end

  sum_t root;
  assign root      = all_sum[ROOT*SW +: SW];
  assign out_valid = all_vld[K];
  assign found     = root.found;
  assign i_x       = root.wit_i.x;
  assign i_y       = root.wit_i.y;
  assign j_x       = root.wit_j.x;
  assign j_y       = root.wit_j.y;

  AST_WITNESS_WITHIN_EXTREMES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && found) |-> ((root.a_left.x <= i_x) && (root.a_low.y <= i_y) &&
                              (root.b_right.x >= j_x) && (root.b_high.y >= j_y))); // R4

endmodule

// File: tb/quadtree_pair_detector_tb.sv
module quadtree_pair_detector_tb;

  localparam int K        = 3;
  localparam int N        = 1 << K;
  localparam int NC       = N * N;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [NC-1:0] a_map = '0;
  logic [NC-1:0] b_map = '0;
  logic          out_valid;
  logic          found;
  logic [K-1:0]  i_x, i_y, j_x, j_y;

  quadtree_pair_detector #(.K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_map(a_map), .b_map(b_map),
    .out_valid(out_valid), .found(found),
    .i_x(i_x), .i_y(i_y), .j_x(j_x), .j_y(j_y)
  );

  always #(CLK_PER/2) clk = ~clk;

  typedef struct {
    logic [NC-1:0] a;
    logic [NC-1:0] b;
    bit            exp_found;
    bit            exact;
    int            ex_ix, ex_iy, ex_jx, ex_jy;
    int            stamp;
    string         tag;
  } item_t;

  item_t sb_q[$];
  item_t mon_it;
  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int at(input int x, input int y);
    return y * N + x;
  endfunction

  // exhaustive reference: every a cell against every b cell
  function automatic bit pair_ref(input logic [NC-1:0] a, input logic [NC-1:0] b);
    for (int ia = 0; ia < NC; ia++) begin
      if (a[ia]) begin
        for (int ib = 0; ib < NC; ib++) begin
          if (b[ib] && ((ia % N) < (ib % N)) && ((ia / N) < (ib / N))) return 1'b1;
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_map(input logic [NC-1:0] a, input logic [NC-1:0] b,
                          input string tag);
    item_t it;
    @(negedge clk);
    a_map     = a;
    b_map     = b;
    in_valid  = 1'b1;
    it.a      = a;
    it.b      = b;
    it.exp_found = pair_ref(a, b);
    it.exact  = 1'b0;
    it.ex_ix  = 0; it.ex_iy = 0; it.ex_jx = 0; it.ex_jy = 0;
    it.stamp  = cyc;
    it.tag    = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_exact(input logic [NC-1:0] a, input logic [NC-1:0] b,
                            input int ix, input int iy, input int jx, input int jy);
    push_map(a, b, "R5");
    sb_q[sb_q.size()-1].exact = 1'b1;
    sb_q[sb_q.size()-1].ex_ix = ix;
    sb_q[sb_q.size()-1].ex_iy = iy;
    sb_q[sb_q.size()-1].ex_jx = jx;
    sb_q[sb_q.size()-1].ex_jy = jy;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [NC-1:0] rand_map(input int density);
    logic [NC-1:0] m;
    for (int c = 0; c < NC; c++) m[c] = ($urandom_range(0, density - 1) == 0);
    return m;
  endfunction

  function automatic logic [NC-1:0] one(input int x, input int y);
    logic [NC-1:0] m;
    m = '0;
    m[at(x, y)] = 1'b1;
    return m;
  endfunction

  // monitor: one scoreboard entry per result pulse
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    end else if (out_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6", "pulse with nothing pending", 1, 0);
      end else begin
        mon_it = sb_q.pop_front();
        chk(cyc - mon_it.stamp == K, "R6", "latency", cyc - mon_it.stamp, K);
        chk(found == mon_it.exp_found, mon_it.tag, "found",
            int'(found), int'(mon_it.exp_found));
        if (found && mon_it.exp_found) begin
          chk(mon_it.a[at(int'(i_x), int'(i_y))] == 1'b1, "R4", "a at witness i",
              at(int'(i_x), int'(i_y)), 1);
          chk(mon_it.b[at(int'(j_x), int'(j_y))] == 1'b1, "R4", "b at witness j",
              at(int'(j_x), int'(j_y)), 1);
          chk((i_x < j_x) && (i_y < j_y), "R4", "witness relation",
              at(int'(i_x), int'(i_y)), at(int'(j_x), int'(j_y)));
          if (mon_it.exact) begin
            chk(int'(i_x) == mon_it.ex_ix && int'(i_y) == mon_it.ex_iy, "R5",
                "witness i", at(int'(i_x), int'(i_y)), at(mon_it.ex_ix, mon_it.ex_iy));
            chk(int'(j_x) == mon_it.ex_jx && int'(j_y) == mon_it.ex_jy, "R5",
                "witness j", at(int'(j_x), int'(j_y)), at(mon_it.ex_jx, mon_it.ex_jy));
          end
        end
      end
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    while (cyc < WD_LIMIT) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", cyc, WD_LIMIT);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "out_valid idle after reset", int'(out_valid), 0);
    end

    // R3: empty maps
    push_map('0, '0, "R3");
    push_map(rand_map(2), '0, "R3");
    push_map('0, rand_map(2), "R3");
    idle(2);

    // R2: shared column, shared row, then the diagonal neighbour
    push_map(one(2, 3), one(2, 6), "R2");
    push_map(one(2, 3), one(5, 3), "R2");
    push_map(one(2, 3), one(2, 6) | one(5, 3), "R2");
    push_map(one(2, 3), one(3, 4), "R2");
    push_map(one(4, 4), one(4, 4), "R2");
    idle(2);

    // R1: grid corners and direction
    push_map(one(0, 0), one(N-1, N-1), "R1");
    push_map(one(N-1, N-1), one(0, 0), "R1");
    push_map(one(N-2, N-2), one(N-1, N-1), "R1");
    push_map(one(0, N-1), one(N-1, 0), "R1");
    push_map(one(N-1, 0), one(0, N-1), "R1");
    push_map(one(3, 3), one(4, 4), "R1");
    push_map(one(3, 4), one(4, 3), "R1");
    idle(1);

    // R5: an inner-quadrant pair outranks the diagonal pair
    push_exact(one(0, 0), one(1, 1) | one(N-1, N-1), 0, 0, 1, 1);
    idle(3);

    // R1 with gaps: assorted densities
    for (int t = 0; t < 40; t++) begin
      push_map(rand_map(2 + (t % 5) * 6), rand_map(2 + ((t / 5) % 5) * 6), "R1");
      idle(1 + (t % 3));
    end

    // R7: long back-to-back bursts, sparse enough that found varies
    for (int t = 0; t < 200; t++) begin
      push_map(rand_map(8 + (t % 4) * 8), rand_map(8 + ((t + 1) % 4) * 8), "R7");
    end
    idle(1);

    while (sb_q.size() != 0) @(negedge clk);
    idle(K + 2);
    summary();
  end

endmodule